// File: doc/BRIEF.md
# LCD Controller Register and Interrupt Unit

This block is the register slave of a color LCD controller. It sits in a 4 KB window of 32-bit words. It stores the four panel timing words, the upper and lower frame base addresses, the control word and the interrupt enable mask. From those registers it derives the active pixel columns, the active line count, the pixel-depth code and the ordering flags that the pixel pipeline uses. It also decodes the palette window and passes that window to a separate palette store. Identification bytes are returned at the top of the window.

A built-in frame-rate counter runs only while the display is enabled. At the end of each period it raises the next-base and vertical-compare status bits. Software clears these bits by writing ones to the clear register. A single level interrupt reports any raw status bit whose mask bit is set.

A strap input, `variant_i`, selects the flavour of the block. The value 0 is the base layout. Any nonzero value exchanges the mask and control words between word offsets 6 and 7. Bit 1 of the strap selects the extended identification bytes.

Top module: `lcd_reg_unit`

## Requirements
- R1: After reset, every register reads as zero, `irq_o` is low, `enabled_o` is low, and no frame tick occurs until the display is enabled.
- R2: `cols_o` equals ((timing0 AND 0xFC) + 4) * 4. `rows_o` equals (timing1 AND 0x3FF) + 1. Both follow the register one cycle after the write to byte offset 0x00 (timing0) or 0x04 (timing1).
- R3: The following words read back as written: timing words at byte offsets 0x00 to 0x0C, upper base at 0x10, lower base at 0x14. Byte offset 0x2C reads the upper base and 0x30 reads the lower base. Writes to 0x2C and 0x30 change nothing.
- R4: When `variant_i` is 0, byte offset 0x18 is the mask and 0x1C is the control word. When `variant_i` is nonzero, the two are exchanged for both reads and writes. The mask stores only its low 5 bits; the other bits read as zero.
- R5: `enabled_o` is high only when control bit 0 and control bit 11 are both 1.
- R6: `depth_o` is control bits [3:1], `bgr_o` is bit 8, `be_byte_o` is bit 9 and `be_pix_o` is bit 10.
- R7: While the display is enabled, raw status bits 2 and 3 become 1 exactly TICK_CYCLES cycles after the write to the control word, and again every TICK_CYCLES cycles after that. No tick occurs while the display is disabled.
- R8: A write to the control word restarts the tick period if the write leaves the display enabled, and stops the tick if it leaves the display disabled.
- R9: `irq_o` is high exactly when (raw status AND mask) is nonzero. Byte offset 0x24 reads raw AND mask, and byte offset 0x20 reads raw status. Writes to 0x20 are ignored.
- R10: A write to byte offset 0x28 clears each raw status bit whose data bit is 1. If a tick lands in the same cycle, the bits the tick sets stay 1.
- R11: Byte offsets 0xFE0 to 0xFFC return one identification byte per word. When `variant_i[1]` is 0, the bytes are 0x10,0x11,0x04,0x00,0x0D,0xF0,0x05,0xB1. When it is 1, the first four bytes are 0x11,0x11,0x24,0x00 and the last four are unchanged.
- R12: Unmapped or misaligned offsets read as zero and ignore writes.
- R13: For byte offsets 0x200 to 0x3FF with `req_i` high, `pal_sel_o` is high, `pal_idx_o` is the word index within that range, and `rdata_o` equals `pal_rdata_i`. Writes there leave every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| variant_i | input | 2 | Strap: 0 = base layout; nonzero = mask and control exchanged; bit 1 = extended ID |
| req_i | input | 1 | Access request |
| we_i | input | 1 | Write enable (1 = write, 0 = read) |
| addr_i | input | 12 | Byte address within the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data (combinational) |
| pal_sel_o | output | 1 | Access falls in the palette window |
| pal_idx_o | output | 7 | Palette word index |
| pal_rdata_i | input | 32 | Read data from the palette store |
| cols_o | output | 11 | Active pixel columns |
| rows_o | output | 11 | Active lines |
| depth_o | output | 3 | Pixel-depth code |
| bgr_o | output | 1 | BGR component order |
| be_byte_o | output | 1 | Big-endian byte order |
| be_pix_o | output | 1 | Big-endian pixel order within a byte |
| enabled_o | output | 1 | Display enabled (enable and power bits both set) |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds the block with TICK_CYCLES set to 40. With that value, several complete frame periods fit into a short run. The bench checks the cycle just before each tick and the cycle of the tick itself. It also rewrites the control word part-way through a period to show that the restart moves the next tick, and it lines up a clear write with the tick cycle. All four strap values are applied, which covers both the exchanged mask and control layout and both sets of identification bytes.

// File: rtl/lcd_reg_pkg.sv
package lcd_reg_pkg;
  localparam int unsigned IRQ_W  = 5;
  localparam int unsigned NB_BIT = 2;
  localparam int unsigned VC_BIT = 3;

  localparam int unsigned CTL_EN    = 0;
  localparam int unsigned CTL_BGR   = 8;
  localparam int unsigned CTL_BEBYT = 9;
  localparam int unsigned CTL_BEPIX = 10;
  localparam int unsigned CTL_PWR   = 11;

  localparam logic [3:0] W_UPBASE = 4'd4;
  localparam logic [3:0] W_LPBASE = 4'd5;
  localparam logic [3:0] W_SLOT_A = 4'd6;
  localparam logic [3:0] W_SLOT_B = 4'd7;
  localparam logic [3:0] W_RAW    = 4'd8;
  localparam logic [3:0] W_MSK    = 4'd9;
  localparam logic [3:0] W_CLR    = 4'd10;
  localparam logic [3:0] W_UPCUR  = 4'd11;
  localparam logic [3:0] W_LPCUR  = 4'd12;

  typedef struct packed {
    logic       pal_hit;
    logic       id_hit;
    logic       reg_hit;
    logic [3:0] reg_idx;
    logic [6:0] pal_idx;
    logic [2:0] id_idx;
  } dec_t;

  function automatic logic [7:0] id_byte(input logic ext, input logic [2:0] idx);
    case (idx)
      3'd0:    id_byte = ext ? 8'h11 : 8'h10;
      3'd1:    id_byte = 8'h11;
      3'd2:    id_byte = ext ? 8'h24 : 8'h04;
      3'd3:    id_byte = 8'h00;
      3'd4:    id_byte = 8'h0D;
      3'd5:    id_byte = 8'hF0;
      3'd6:    id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/lcd_addr_dec.sv
module lcd_addr_dec
  import lcd_reg_pkg::*;
(
  input  logic [11:0] addr_i,
  output dec_t        dec_o
);
  logic [9:0] word;
  logic       aligned;

  assign word    = addr_i[11:2];
  assign aligned = (addr_i[1:0] == 2'b00);

  always_comb begin
    dec_o         = '0;
    dec_o.pal_hit = aligned && (word[9:7] == 3'b001);
    dec_o.id_hit  = aligned && (word[9:3] == 7'h7F);
    dec_o.reg_hit = aligned && (word[9:4] == 6'd0) && (word[3:0] <= W_LPCUR);
    dec_o.reg_idx = word[3:0];
    dec_o.pal_idx = word[6:0];
    dec_o.id_idx  = word[2:0];
  end
endmodule

// File: rtl/lcd_geom.sv
module lcd_geom #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DIM_W  = 11
) (
  input  logic [DATA_W-1:0] tim0_i,
  input  logic [DATA_W-1:0] tim1_i,
  output logic [DIM_W-1:0]  cols_o,
  output logic [DIM_W-1:0]  rows_o
);
  // columns come in groups of 16 pixels
  logic [DIM_W-1:0] grp;

  assign grp    = DIM_W'(tim0_i[7:2]) + DIM_W'(1);
  assign cols_o = grp << 4;
  assign rows_o = DIM_W'(tim1_i[9:0]) + DIM_W'(1);
endmodule

// File: rtl/lcd_frame_tick.sv
module lcd_frame_tick #(
  parameter int unsigned CYCLES = 1666667
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic restart_i,
  output logic tick_o
);
  localparam int unsigned CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = en_i && !restart_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   cnt_q <= '0;
    else if (restart_i || !en_i || cnt_q == LAST)  cnt_q <= '0;
    else                                           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lcd_irq_ctrl.sv
module lcd_irq_ctrl
  import lcd_reg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             mask_we_i,
  input  logic             clr_we_i,
  input  logic [IRQ_W-1:0] wdata_i,
  output logic [IRQ_W-1:0] raw_o,
  output logic [IRQ_W-1:0] mask_o,
  output logic             irq_o
);
  logic [IRQ_W-1:0] set_v, clr_v;

  always_comb begin
    set_v = '0;
    if (tick_i) begin
      set_v[NB_BIT] = 1'b1;
      set_v[VC_BIT] = 1'b1;
    end
    clr_v = clr_we_i ? wdata_i : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_o  <= '0;
      mask_o <= '0;
    end else begin
      raw_o <= (raw_o & ~clr_v) | set_v;  // a tick wins over a clear
      if (mask_we_i) mask_o <= wdata_i;
    end
  end

  assign irq_o = |(raw_o & mask_o);
endmodule

// File: rtl/lcd_reg_unit.sv
module lcd_reg_unit
  import lcd_reg_pkg::*;
#(
  parameter int unsigned TICK_CYCLES = 1666667,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned DIM_W       = 11,
  parameter int unsigned N_TIM       = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        variant_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [11:0]       addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              pal_sel_o,
  output logic [6:0]        pal_idx_o,
  input  logic [DATA_W-1:0] pal_rdata_i,
  output logic [DIM_W-1:0]  cols_o,
  output logic [DIM_W-1:0]  rows_o,
  output logic [2:0]        depth_o,
  output logic              bgr_o,
  output logic              be_byte_o,
  output logic              be_pix_o,
  output logic              enabled_o,
  output logic              irq_o
);
  dec_t              dec;
  logic              wr, swapped;
  logic [3:0]        ctrl_idx, mask_idx;
  logic              ctrl_we, mask_we, clr_we, tick_w;
  logic [DATA_W-1:0] tim_q [N_TIM];
  logic [DATA_W-1:0] up_q, lp_q, ctrl_q;
  logic [IRQ_W-1:0]  raw_w, mask_w;
  logic [DATA_W-1:0] raw_x, mask_x;

  lcd_addr_dec i_dec (.addr_i(addr_i), .dec_o(dec));

  assign wr       = req_i && we_i && dec.reg_hit;
  assign swapped  = (variant_i != 2'd0);
  assign ctrl_idx = swapped ? W_SLOT_A : W_SLOT_B;
  assign mask_idx = swapped ? W_SLOT_B : W_SLOT_A;
  assign ctrl_we  = wr && (dec.reg_idx == ctrl_idx);
  assign mask_we  = wr && (dec.reg_idx == mask_idx);
  assign clr_we   = wr && (dec.reg_idx == W_CLR);

  for (genvar g = 0; g < N_TIM; g++) begin : g_tim
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  tim_q[g] <= '0;
      else if (wr && dec.reg_idx == 4'(g))          tim_q[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q   <= '0;
      lp_q   <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr && dec.reg_idx == W_UPBASE) up_q   <= wdata_i;
      if (wr && dec.reg_idx == W_LPBASE) lp_q   <= wdata_i;
      if (ctrl_we)                       ctrl_q <= wdata_i;
    end
  end

  assign enabled_o = ctrl_q[CTL_EN] & ctrl_q[CTL_PWR];
  assign depth_o   = ctrl_q[3:1];
  assign bgr_o     = ctrl_q[CTL_BGR];
  assign be_byte_o = ctrl_q[CTL_BEBYT];
  assign be_pix_o  = ctrl_q[CTL_BEPIX];

  lcd_geom #(.DATA_W(DATA_W), .DIM_W(DIM_W)) i_geom (
    .tim0_i(tim_q[0]), .tim1_i(tim_q[1]), .cols_o(cols_o), .rows_o(rows_o)
  );

  lcd_frame_tick #(.CYCLES(TICK_CYCLES)) i_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(enabled_o),
    .restart_i(ctrl_we), .tick_o(tick_w)
  );

  lcd_irq_ctrl i_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_w),
    .mask_we_i(mask_we), .clr_we_i(clr_we), .wdata_i(wdata_i[IRQ_W-1:0]),
    .raw_o(raw_w), .mask_o(mask_w), .irq_o(irq_o)
  );

  assign raw_x     = DATA_W'(raw_w);
  assign mask_x    = DATA_W'(mask_w);
  assign pal_sel_o = req_i && dec.pal_hit;
  assign pal_idx_o = dec.pal_idx;

  always_comb begin
    rdata_o = '0;
    if (dec.pal_hit) begin
      rdata_o = pal_rdata_i;
    end else if (dec.id_hit) begin
      rdata_o = DATA_W'(id_byte(variant_i[1], dec.id_idx));
    end else if (dec.reg_hit) begin
      case (dec.reg_idx)
        4'd0, 4'd1, 4'd2, 4'd3: rdata_o = tim_q[dec.reg_idx[1:0]];
        W_UPBASE, W_UPCUR:      rdata_o = up_q;
        W_LPBASE, W_LPCUR:      rdata_o = lp_q;
        W_SLOT_A:               rdata_o = swapped ? ctrl_q : mask_x;
        W_SLOT_B:               rdata_o = swapped ? mask_x : ctrl_q;
        W_RAW:                  rdata_o = raw_x;
        W_MSK:                  rdata_o = raw_x & mask_x;
        default:                rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/lcd_reg_unit_chk.sv
module lcd_reg_unit_chk
  import lcd_reg_pkg::*;
#(
  parameter int unsigned DIM_W = 11
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       variant_i,
  input logic             req_i,
  input logic             we_i,
  input logic [11:0]      addr_i,
  input logic [31:0]      wdata_i,
  input logic             tick_i,
  input logic [IRQ_W-1:0] raw_i,
  input logic [DIM_W-1:0] cols_i,
  input logic [DIM_W-1:0] rows_i,
  input logic             enabled_i,
  input logic             irq_i
);
  logic        wr;
  logic [11:0] ctrl_addr;

  assign wr        = req_i && we_i;
  assign ctrl_addr = (variant_i != 2'd0) ? 12'h018 : 12'h01C;

  p_cols_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == 12'h000) |=>
      cols_i == ((DIM_W'($past(wdata_i[7:2])) + DIM_W'(1)) << 4));

  p_rows_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == 12'h004) |=>
      rows_i == (DIM_W'($past(wdata_i[9:0])) + DIM_W'(1)));

  p_enable_pair_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == ctrl_addr && !(wdata_i[0] && wdata_i[11])) |=> !enabled_i);

  p_no_tick_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enabled_i |-> !tick_i);

  p_tick_sets_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (raw_i[VC_BIT] && raw_i[NB_BIT]));

  p_clear_all_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == 12'h028 && (&wdata_i[IRQ_W-1:0]) && !tick_i) |=> !irq_i);
endmodule

bind lcd_reg_unit lcd_reg_unit_chk #(.DIM_W(DIM_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .variant_i(variant_i), .req_i(req_i),
  .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i), .tick_i(tick_w),
  .raw_i(raw_w), .cols_i(cols_o), .rows_i(rows_o), .enabled_i(enabled_o),
  .irq_i(irq_o)
);

// File: tb/test_lcd_reg_unit.sv
module test_lcd_reg_unit;
  localparam int unsigned P = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  variant = 2'd0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata, pal_rdata = 32'hA5C3_1E77;
  logic        pal_sel, bgr, be_byte, be_pix, enabled, irq;
  logic [6:0]  pal_idx;
  logic [10:0] cols, rows;
  logic [2:0]  depth;
  int          n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  lcd_reg_unit #(.TICK_CYCLES(P)) i_lcd_reg_unit (
    .clk_i(clk), .rst_ni(rst_n), .variant_i(variant), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .pal_sel_o(pal_sel),
    .pal_idx_o(pal_idx), .pal_rdata_i(pal_rdata), .cols_o(cols), .rows_o(rows),
    .depth_o(depth), .bgr_o(bgr), .be_byte_o(be_byte), .be_pix_o(be_pix),
    .enabled_o(enabled), .irq_o(irq)
  );

  function automatic logic [31:0] exp_cols(input logic [31:0] t);
    return ((t & 32'hFC) + 32'd4) * 32'd4;
  endfunction
  function automatic logic [31:0] exp_rows(input logic [31:0] t);
    return (t & 32'h3FF) + 32'd1;
  endfunction
  function automatic logic [7:0] exp_id(input logic ext, input int i);
    logic [7:0] b [8] = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    if (ext && i == 0) return 8'h11;
    if (ext && i == 2) return 8'h24;
    return b[i];
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // drive at negedge; the write lands on the following posedge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    req = 1'b0;
  endtask

  task automatic wait_n(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v, c, d;
    void'($urandom(32'h5EED_0042));
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);

    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 enabled", 32'(enabled), 0);
    for (int a = 0; a <= 12; a++) begin
      rd(12'(a * 4), d); chk("R1 reg zero", d, 0);
    end
    wait_n(P + 2);
    rd(12'h020, d); chk("R1 no tick while off", d, 0);

    // R2/R3 geometry and readback, random
    for (int i = 0; i < 60; i++) begin
      v = $urandom; wr(12'h000, v);
      chk("R2 cols", 32'(cols), exp_cols(v));
      rd(12'h000, d); chk("R3 tim0", d, v);
      v = $urandom; wr(12'h004, v);
      chk("R2 rows", 32'(rows), exp_rows(v));
      rd(12'h004, d); chk("R3 tim1", d, v);
    end
    wr(12'h000, 32'hFF); chk("R2 cols max", 32'(cols), 1024);
    wr(12'h004, 32'h3FF); chk("R2 rows max", 32'(rows), 1024);
    wr(12'h000, 32'h03); chk("R2 cols min", 32'(cols), 16);
    v = $urandom; wr(12'h008, v); rd(12'h008, d); chk("R3 tim2", d, v);
    v = $urandom; wr(12'h00C, v); rd(12'h00C, d); chk("R3 tim3", d, v);
    v = $urandom; wr(12'h010, v); rd(12'h010, d); chk("R3 upbase", d, v);
    rd(12'h02C, d); chk("R3 upcur", d, v);
    wr(12'h02C, ~v); rd(12'h010, d); chk("R3 upcur write ignored", d, v);
    c = $urandom; wr(12'h014, c); rd(12'h030, d); chk("R3 lpcur", d, c);
    wr(12'h030, ~c); rd(12'h014, d); chk("R3 lpcur write ignored", d, c);

    // R5/R6 control fields, random (variant 0: control at 0x1C)
    for (int i = 0; i < 60; i++) begin
      c = $urandom & 32'hFFFF_F7FE;
      c |= {20'd0, 1'($urandom), 10'd0, 1'($urandom)};
      wr(12'h01C, c);
      chk("R5 enabled", 32'(enabled), 32'(c[0] & c[11]));
      chk("R6 depth", 32'(depth), 32'(c[3:1]));
      chk("R6 bgr", 32'(bgr), 32'(c[8]));
      chk("R6 be_byte", 32'(be_byte), 32'(c[9]));
      chk("R6 be_pix", 32'(be_pix), 32'(c[10]));
      rd(12'h01C, d); chk("R4 ctrl readback", d, c);
    end
    wr(12'h01C, 32'h1); chk("R5 enable without power", 32'(enabled), 0);
    wr(12'h01C, 32'h800); chk("R5 power without enable", 32'(enabled), 0);
    wr(12'h01C, 0); wr(12'h028, 32'hFFFF_FFFF);
    rd(12'h020, d); chk("R10 clear all", d, 0);

    // R4 mask/control placement
    wr(12'h018, 32'hFFFF_FFEA); rd(12'h018, d); chk("R4 mask v0", d, 32'h0A);
    chk("R4 mask not control", 32'(enabled), 0);
    wr(12'h018, 0);
    variant = 2'd1;
    wr(12'h018, 32'h0000_0F02); chk("R4 swapped ctrl", 32'(depth), 1);
    rd(12'h01C, d); chk("R4 swapped mask", d, 0);
    wr(12'h01C, 32'h13); rd(12'h01C, d); chk("R4 swapped mask rd", d, 32'h13);
    rd(12'h018, d); chk("R4 swapped ctrl rd", d, 32'h0F02);
    wr(12'h018, 0); wr(12'h01C, 0); wr(12'h028, 32'h1F);
    variant = 2'd0;

    // R7 first tick timing
    wr(12'h01C, 32'h801);
    wait_n(P - 1); rd(12'h020, d); chk("R7 before tick", d, 0);
    wait_n(1);     rd(12'h020, d); chk("R7 tick sets", d, 32'hC);
    chk("R9 masked off", 32'(irq), 0);
    wait_n(P - 1); wr(12'h028, 32'hC);  // lands on the next tick edge
    rd(12'h020, d); chk("R10 tick wins over clear", d, 32'hC);
    wr(12'h01C, 0);
    wait_n(2 * P); wr(12'h028, 32'hC);
    wait_n(P + 2); rd(12'h020, d); chk("R8 disable stops tick", d, 0);

    // R8 restart
    wr(12'h01C, 32'h801);
    wait_n(P - 6); wr(12'h01C, 32'h803);
    wait_n(5);     rd(12'h020, d); chk("R8 old period dropped", d, 0);
    wait_n(P - 6); rd(12'h020, d); chk("R8 before new tick", d, 0);
    wait_n(1);     rd(12'h020, d); chk("R8 new tick", d, 32'hC);
    wr(12'h01C, 0);

    // R9/R10 interrupt and clear, display off
    rd(12'h020, d); chk("R9 raw", d, 32'hC);
    wr(12'h020, 0); rd(12'h020, d); chk("R9 raw write ignored", d, 32'hC);
    wr(12'h018, 32'h4); chk("R9 irq nb", 32'(irq), 1);
    rd(12'h024, d); chk("R9 masked", d, 32'h4);
    wr(12'h018, 0); chk("R9 irq masked off", 32'(irq), 0);
    wr(12'h018, 32'h8); chk("R9 irq vc", 32'(irq), 1);
    wr(12'h028, 32'h8); chk("R10 irq after clear", 32'(irq), 0);
    rd(12'h020, d); chk("R10 partial clear", d, 32'h4);
    wr(12'h028, 32'h4); rd(12'h020, d); chk("R10 cleared", d, 0);

    // R11 identification
    for (int vv = 0; vv < 4; vv++) begin
      variant = 2'(vv);
      for (int i = 0; i < 8; i++) begin
        rd(12'hFE0 + 12'(i * 4), d);
        chk("R11 id", d, 32'(exp_id(variant[1], i)));
      end
    end
    variant = 2'd0;

    // R12 unmapped and misaligned
    rd(12'h010, v);
    wr(12'h040, 32'hDEAD_BEEF); rd(12'h040, d); chk("R12 unmapped read", d, 0);
    wr(12'h011, 32'h1234_5678); rd(12'h010, d); chk("R12 misaligned write", d, v);
    rd(12'h011, d); chk("R12 misaligned read", d, 0);
    wr(12'h034, 32'hFFFF_FFFF); rd(12'h034, d); chk("R12 gap read", d, 0);

    // R13 palette window
    req = 1'b1; we = 1'b0; addr = 12'h204; #1;
    chk("R13 sel", 32'(pal_sel), 1);
    chk("R13 idx", 32'(pal_idx), 1);
    chk("R13 rdata", rdata, pal_rdata);
    addr = 12'h3FC; #1; chk("R13 idx top", 32'(pal_idx), 127);
    addr = 12'h400; #1; chk("R13 outside", 32'(pal_sel), 0);
    req = 1'b0;
    wr(12'h210, 32'h0000_0FFF); rd(12'h010, d); chk("R13 write no effect", d, v);
    chk("R13 ctrl untouched", 32'(enabled), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule